// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block runs the multi-cycle state machine that takes a small 16-bit processor into a device interrupt service routine and brings it back out. It owns the program status word, the parked user stack pointer and the parked supervisor stack pointer. It drives write strobes for the core's R6 (stack pointer) and PC. Memory traffic for the supervisor stack and the vector table goes through one simple port. A write completes in its own cycle. Read data returns one cycle after the read strobe.

When the core signals that an instruction has finished, a device request is taken if the device enable is set and its level beats the running level. The sequencer then switches to the supervisor stack if the interrupted code was unprivileged, and pushes the status word and then the PC. It raises the privilege and the running level, clears the condition codes, and loads the PC from the vector table. The return sequence pops the PC and then the status word. It goes back to the user stack when the restored status word says the code is unprivileged.

Top module: `intr_seq`

## Requirements
- R1: A device request is taken only in a cycle where the sequencer is idle and all four conditions hold: `dev_req` = 1, `dev_ie` = 1, `instr_done` = 1, and `dev_pri` strictly greater than `psr_out[10:8]`. Otherwise the request causes no memory access and no change to `psr_out`.
- R2: After reset, `psr_out` = 16'h8000. In this word, bit 15 = 1 means unprivileged, bits [10:8] hold the running level 0, and bits [2:0] hold the N, Z, P codes at 0. Also after reset, `busy`, `done` and `priv_err` are 0, and the saved supervisor stack pointer is `SSP_RST`.
- R3: On entry from unprivileged code, the incoming R6 is kept as the user stack pointer and the stack is rebuilt from the saved supervisor pointer. R6 is finally written with that pointer minus 2. On entry from privileged code, the stack continues from the incoming R6.
- R4: Entry writes the old status word at SP-1 and then the old PC at SP-2, decrementing the pointer before each write. No other register is written to memory.
- R5: After entry, `psr_out` has bit 15 = 0, bits [10:8] = the accepted `dev_pri`, and bits [2:0] = 0.
- R6: The new PC is the word read from address `VEC_BASE` (16'h0100) + `dev_vec`, and it is written through `pc_we`/`pc_wdata`.
- R7: Return reads the PC at R6 and then the status word at R6+1, incrementing the pointer after each read. If the restored bit 15 is 1, the pointer after the pops is saved as the supervisor pointer and R6 gets the user pointer back. The PC gets the popped value.
- R8: If the restored bit 15 is 0 (a nested return), no swap happens and R6 gets the pointer after the pops.
- R9: `rti_req` while `psr_out[15]` = 1 pulses `priv_err` for one cycle. It causes no memory read, no `done`, and no change to the PC, R6 or `psr_out`.
- R10: For entry, `done`, `pc_we` and `r6_we` pulse together for one cycle, four cycles after the accepting edge. For return, they pulse three cycles after the accepting edge.
- R11: A popped status word keeps only bits 15, [10:8] and [2:0]. All other bits read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_req | input | 1 | Device requests service |
| dev_ie | input | 1 | Device interrupt enable bit |
| dev_pri | input | 3 | Device level |
| dev_vec | input | 8 | Device vector number |
| instr_done | input | 1 | Current instruction has completed |
| rti_req | input | 1 | Return-from-interrupt instruction issued |
| cur_pc | input | 16 | PC of the next instruction to run |
| cur_r6 | input | 16 | Current R6 value |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe, data one cycle later |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data |
| r6_we | output | 1 | Write strobe for R6 |
| r6_wdata | output | 16 | New R6 value |
| pc_we | output | 1 | Write strobe for PC |
| pc_wdata | output | 16 | New PC value |
| psr_out | output | 16 | Program status word |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished this cycle |
| priv_err | output | 1 | Return attempted from unprivileged code |

## Verification
The bench aims at the level compare at equality and at level 0, since a `>=` test would start service for a device that ties with the running code. It runs a nested entry from privileged code: a design that always swapped stacks would reload R6 from the stale supervisor pointer and overwrite the outer frame. It also runs the nested return, where swapping anyway would hand the user pointer to privileged code. It forces a return in unprivileged mode, where a missing guard would pop garbage into the PC. It also restores a status word with stray bits and set condition codes, so that unmasked bits or codes that survive the next entry show up at `psr_out`.

// File: rtl/intr_seq_pkg.sv
package intr_seq_pkg;
  localparam int PSR_W    = 16;
  localparam int PRIV_BIT = 15;
  localparam int PRI_LSB  = 8;
  localparam int PRI_W    = 3;
  localparam int CC_W     = 3;
  localparam logic [PSR_W-1:0] PSR_KEEP =
    (16'h1 << PRIV_BIT) | (((16'h1 << PRI_W) - 16'h1) << PRI_LSB) | ((16'h1 << CC_W) - 16'h1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_PUSH_PSR, ST_PUSH_PC, ST_VEC_RD, ST_VEC_WAIT,
    ST_POP_PC, ST_POP_PSR, ST_POP_FIN
  } seq_st_t;
endpackage

// File: rtl/intr_gate.sv
module intr_gate #(
  parameter int PRI_W = 3
) (
  input  logic             dev_req,
  input  logic             dev_ie,
  input  logic [PRI_W-1:0] dev_pri,
  input  logic [PRI_W-1:0] run_pri,
  input  logic             instr_done,
  input  logic             idle,
  input  logic             rti_go,
  output logic             take
);
  // return instruction owns the idle cycle it arrives in
  assign take = idle & ~rti_go & dev_req & dev_ie & instr_done & (dev_pri > run_pri);
endmodule

// File: rtl/intr_ctx.sv
module intr_ctx
  import intr_seq_pkg::*;
#(
  parameter int              DW      = 16,
  parameter logic [DW-1:0]   PSR_RST = 16'h8000,
  parameter logic [DW-1:0]   SSP_RST = 16'h3000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             entry_ld,
  input  logic [PRI_W-1:0] entry_pri,
  input  logic             pop_ld,
  input  logic [DW-1:0]    pop_psr,
  input  logic             usp_ld,
  input  logic [DW-1:0]    usp_nx,
  input  logic             ssp_ld,
  input  logic [DW-1:0]    ssp_nx,
  output logic [DW-1:0]    psr,
  output logic [DW-1:0]    usp,
  output logic [DW-1:0]    ssp
);
  logic [DW-1:0] psr_d;
  logic          psr_en;

  always_comb begin
    psr_d  = psr;
    psr_en = entry_ld | pop_ld;
    if (entry_ld) begin
      psr_d = '0;
      psr_d[PRI_LSB +: PRI_W] = entry_pri;
    end else if (pop_ld) begin
      psr_d = pop_psr & PSR_KEEP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psr <= PSR_RST;
      usp <= '0;
      ssp <= SSP_RST;
    end else begin
      if (psr_en) psr <= psr_d;
      if (usp_ld) usp <= usp_nx;
      if (ssp_ld) ssp <= ssp_nx;
    end
  end

  AST_ENTRY_SUPV: assert property (@(posedge clk) disable iff (!rst_n)
    entry_ld |=> (psr[PRIV_BIT] == 1'b0 && psr[CC_W-1:0] == '0)); // R5
  AST_PRI_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    entry_ld |=> (psr[PRI_LSB +: PRI_W] > $past(psr[PRI_LSB +: PRI_W]))); // R1
  AST_LOAD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(entry_ld && pop_ld)); // R7
endmodule

// File: rtl/intr_ctrl.sv
module intr_ctrl
  import intr_seq_pkg::*;
#(
  parameter int            DW       = 16,
  parameter int            VW       = 8,
  parameter logic [DW-1:0] VEC_BASE = 16'h0100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             rti_req,
  input  logic             priv_n,
  input  logic [DW-1:0]    usp,
  input  logic [DW-1:0]    ssp,
  input  logic [DW-1:0]    psr,
  input  logic [DW-1:0]    cur_pc,
  input  logic [DW-1:0]    cur_r6,
  input  logic [PRI_W-1:0] dev_pri,
  input  logic [VW-1:0]    dev_vec,
  input  logic [DW-1:0]    mem_rdata,
  output logic             rti_go,
  output logic             idle,
  output logic             mem_we,
  output logic             mem_re,
  output logic [DW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  output logic             r6_we,
  output logic [DW-1:0]    r6_wdata,
  output logic             pc_we,
  output logic [DW-1:0]    pc_wdata,
  output logic             done,
  output logic             busy,
  output logic             priv_err,
  output logic             entry_ld,
  output logic [PRI_W-1:0] entry_pri,
  output logic             pop_ld,
  output logic [DW-1:0]    pop_psr,
  output logic             usp_ld,
  output logic [DW-1:0]    usp_nx,
  output logic             ssp_ld,
  output logic [DW-1:0]    ssp_nx
);
  localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

  seq_st_t          st_q, st_d;
  logic [DW-1:0]    sp_q, sp_d, pc_q, pc_d, psv_q, psv_d;
  logic [VW-1:0]    vec_q;
  logic [PRI_W-1:0] pri_q;
  logic             err_d, err_q, sp_en, pc_en, cap_en;

  assign idle     = (st_q == ST_IDLE);
  assign busy     = ~idle;
  assign rti_go   = idle & rti_req;
  assign priv_err = err_q;
  assign entry_pri = pri_q;
  assign pop_psr  = mem_rdata;
  assign usp_nx   = cur_r6;
  assign ssp_nx   = sp_q;

  always_comb begin
    st_d = st_q; sp_d = sp_q; pc_d = pc_q; psv_d = psv_q;
    sp_en = 1'b0; pc_en = 1'b0; cap_en = 1'b0; err_d = 1'b0;
    mem_we = 1'b0; mem_re = 1'b0; mem_addr = sp_q; mem_wdata = '0;
    r6_we = 1'b0; r6_wdata = sp_q; pc_we = 1'b0; pc_wdata = pc_q; done = 1'b0;
    entry_ld = 1'b0; pop_ld = 1'b0; usp_ld = 1'b0; ssp_ld = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (rti_go) begin
          if (priv_n) begin
            err_d = 1'b1;
          end else begin
            st_d = ST_POP_PC; sp_d = cur_r6; sp_en = 1'b1;
          end
        end else if (take) begin
          st_d   = ST_PUSH_PSR;
          sp_d   = priv_n ? ssp : cur_r6;
          sp_en  = 1'b1;
          usp_ld = priv_n;
          pc_d   = cur_pc; pc_en = 1'b1;
          psv_d  = psr; cap_en = 1'b1;
        end
      end
      ST_PUSH_PSR: begin
        mem_we = 1'b1; mem_addr = sp_q - ONE; mem_wdata = psv_q;
        sp_d = sp_q - ONE; sp_en = 1'b1; st_d = ST_PUSH_PC;
      end
      ST_PUSH_PC: begin
        mem_we = 1'b1; mem_addr = sp_q - ONE; mem_wdata = pc_q;
        sp_d = sp_q - ONE; sp_en = 1'b1; entry_ld = 1'b1; st_d = ST_VEC_RD;
      end
      ST_VEC_RD: begin
        mem_re = 1'b1; mem_addr = VEC_BASE + {{(DW-VW){1'b0}}, vec_q};
        st_d = ST_VEC_WAIT;
      end
      ST_VEC_WAIT: begin
        pc_we = 1'b1; pc_wdata = mem_rdata; r6_we = 1'b1; r6_wdata = sp_q;
        done = 1'b1; st_d = ST_IDLE;
      end
      ST_POP_PC: begin
        mem_re = 1'b1; sp_d = sp_q + ONE; sp_en = 1'b1; st_d = ST_POP_PSR;
      end
      ST_POP_PSR: begin
        pc_d = mem_rdata; pc_en = 1'b1;
        mem_re = 1'b1; sp_d = sp_q + ONE; sp_en = 1'b1; st_d = ST_POP_FIN;
      end
      ST_POP_FIN: begin
        pop_ld = 1'b1; pc_we = 1'b1; pc_wdata = pc_q; r6_we = 1'b1; done = 1'b1;
        if (mem_rdata[PRIV_BIT]) begin
          ssp_ld = 1'b1; r6_wdata = usp;
        end else begin
          r6_wdata = sp_q;
        end
        st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; sp_q <= '0; pc_q <= '0; psv_q <= '0;
      vec_q <= '0; pri_q <= '0; err_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      err_q <= err_d;
      if (sp_en) sp_q <= sp_d;
      if (pc_en) pc_q <= pc_d;
      if (cap_en) begin
        psv_q <= psv_d; vec_q <= dev_vec; pri_q <= dev_pri;
      end
    end
  end

  AST_PUSH_DESCEND: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> mem_addr == $past(mem_addr) - ONE); // R4
  AST_POP_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re && $past(mem_re)) |-> mem_addr == $past(mem_addr) + ONE); // R7
  AST_VEC_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re && $past(mem_we)) |-> mem_addr[DW-1:VW] == VEC_BASE[DW-1:VW]); // R6
  AST_PRIV_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && rti_req && priv_n) |=> (priv_err && !busy && !mem_re)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
endmodule

// File: rtl/intr_seq.sv
module intr_seq
  import intr_seq_pkg::*;
#(
  parameter int            DW       = 16,
  parameter int            VW       = 8,
  parameter logic [DW-1:0] VEC_BASE = 16'h0100,
  parameter logic [DW-1:0] PSR_RST  = 16'h8000,
  parameter logic [DW-1:0] SSP_RST  = 16'h3000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dev_req,
  input  logic             dev_ie,
  input  logic [PRI_W-1:0] dev_pri,
  input  logic [VW-1:0]    dev_vec,
  input  logic             instr_done,
  input  logic             rti_req,
  input  logic [DW-1:0]    cur_pc,
  input  logic [DW-1:0]    cur_r6,
  output logic             mem_we,
  output logic             mem_re,
  output logic [DW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic [DW-1:0]    mem_rdata,
  output logic             r6_we,
  output logic [DW-1:0]    r6_wdata,
  output logic             pc_we,
  output logic [DW-1:0]    pc_wdata,
  output logic [DW-1:0]    psr_out,
  output logic             busy,
  output logic             done,
  output logic             priv_err
);
  logic [1:0]       rsync_q;
  logic             rst_i;
  logic             take, idle, rti_go;
  logic             entry_ld, pop_ld, usp_ld, ssp_ld;
  logic [PRI_W-1:0] entry_pri;
  logic [DW-1:0]    pop_psr, usp_nx, ssp_nx, usp, ssp, psr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i   = rsync_q[1];
  assign psr_out = psr;

  intr_gate #(.PRI_W(PRI_W)) u_gate (
    .dev_req(dev_req), .dev_ie(dev_ie), .dev_pri(dev_pri),
    .run_pri(psr[PRI_LSB +: PRI_W]), .instr_done(instr_done),
    .idle(idle), .rti_go(rti_go), .take(take)
  );

  intr_ctx #(.DW(DW), .PSR_RST(PSR_RST), .SSP_RST(SSP_RST)) u_ctx (
    .clk(clk), .rst_n(rst_i),
    .entry_ld(entry_ld), .entry_pri(entry_pri),
    .pop_ld(pop_ld), .pop_psr(pop_psr),
    .usp_ld(usp_ld), .usp_nx(usp_nx), .ssp_ld(ssp_ld), .ssp_nx(ssp_nx),
    .psr(psr), .usp(usp), .ssp(ssp)
  );

  intr_ctrl #(.DW(DW), .VW(VW), .VEC_BASE(VEC_BASE)) u_ctrl (
    .clk(clk), .rst_n(rst_i), .take(take), .rti_req(rti_req),
    .priv_n(psr[PRIV_BIT]), .usp(usp), .ssp(ssp), .psr(psr),
    .cur_pc(cur_pc), .cur_r6(cur_r6), .dev_pri(dev_pri), .dev_vec(dev_vec),
    .mem_rdata(mem_rdata), .rti_go(rti_go), .idle(idle),
    .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .r6_we(r6_we), .r6_wdata(r6_wdata), .pc_we(pc_we), .pc_wdata(pc_wdata),
    .done(done), .busy(busy), .priv_err(priv_err),
    .entry_ld(entry_ld), .entry_pri(entry_pri), .pop_ld(pop_ld), .pop_psr(pop_psr),
    .usp_ld(usp_ld), .usp_nx(usp_nx), .ssp_ld(ssp_ld), .ssp_nx(ssp_nx)
  );

  AST_MEM_ONE_OP: assert property (@(posedge clk) disable iff (!rst_i)
    !(mem_we && mem_re)); // R10
endmodule

// File: tb/intr_seq_tb.sv
module intr_seq_tb;
  logic clk = 1'b0;
  logic rst_n;
  logic dev_req, dev_ie, instr_done, rti_req;
  logic [2:0] dev_pri;
  logic [7:0] dev_vec;
  logic [15:0] core_pc, core_r6;
  logic mem_we, mem_re, r6_we, pc_we, busy, done, priv_err;
  logic [15:0] mem_addr, mem_wdata, rd_q, r6_wdata, pc_wdata, psr_out;
  logic [15:0] mem [0:4095];
  int n_chk = 0, n_fail = 0, n_we = 0, n_re = 0;
  logic [15:0] last_pc, last_r6;

  always #10 clk = ~clk;

  intr_seq u_dut (
    .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .dev_ie(dev_ie), .dev_pri(dev_pri),
    .dev_vec(dev_vec), .instr_done(instr_done), .rti_req(rti_req),
    .cur_pc(core_pc), .cur_r6(core_r6), .mem_we(mem_we), .mem_re(mem_re),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(rd_q),
    .r6_we(r6_we), .r6_wdata(r6_wdata), .pc_we(pc_we), .pc_wdata(pc_wdata),
    .psr_out(psr_out), .busy(busy), .done(done), .priv_err(priv_err)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      core_pc <= 16'h0200; core_r6 <= 16'h0E00; rd_q <= '0;
    end else begin
      if (mem_we) begin mem[mem_addr[11:0]] <= mem_wdata; n_we <= n_we + 1; end
      if (mem_re) begin rd_q <= mem[mem_addr[11:0]]; n_re <= n_re + 1; end
      if (pc_we) core_pc <= pc_wdata;
      if (r6_we) core_r6 <= r6_wdata;
    end
  end

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // returns cycles to done (0 when no done seen); psr settled on return
  task automatic fire(input logic rq, input logic ie, input logic [2:0] pr,
                      input logic idn, input logic [7:0] vc, output int lat);
    @(negedge clk);
    dev_req = rq; dev_ie = ie; dev_pri = pr; instr_done = idn; dev_vec = vc;
    @(negedge clk);
    dev_req = 0; dev_ie = 0; instr_done = 0; lat = 1;
    while (!done && lat < 10) begin @(negedge clk); lat++; end
    if (!done) lat = 0;
    last_pc = pc_wdata; last_r6 = r6_wdata;
    @(negedge clk);
  endtask

  task automatic ret(output int lat);
    @(negedge clk);
    rti_req = 1;
    @(negedge clk);
    rti_req = 0; lat = 1;
    while (!done && lat < 10) begin @(negedge clk); lat++; end
    if (!done) lat = 0;
    last_pc = pc_wdata; last_r6 = r6_wdata;
    @(negedge clk);
  endtask

  // {req, ie, pri[2:0], idone, vec[7:0], accept}
  localparam logic [14:0] TBL [7] = '{
    {1'b1, 1'b1, 3'd3, 1'b1, 8'h05, 1'b1},
    {1'b0, 1'b1, 3'd3, 1'b1, 8'h05, 1'b0},
    {1'b1, 1'b0, 3'd7, 1'b1, 8'h06, 1'b0},
    {1'b1, 1'b1, 3'd0, 1'b1, 8'h07, 1'b0},
    {1'b1, 1'b1, 3'd5, 1'b0, 8'h08, 1'b0},
    {1'b1, 1'b1, 3'd7, 1'b1, 8'hFF, 1'b1},
    {1'b1, 1'b1, 3'd1, 1'b1, 8'h00, 1'b1}
  };

  initial begin
    int lat, we0, re0;
    rst_n = 0; dev_req = 0; dev_ie = 0; dev_pri = 0; dev_vec = 0;
    instr_done = 0; rti_req = 0;
    for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
    for (int v = 0; v < 256; v++) mem[12'h100 + v] = 16'h4000 + 16'(v * 4);
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R2 reset state
    chk(psr_out == 16'h8000, "R2 psr", psr_out, 16'h8000);
    chk({busy, done, priv_err} == 3'b000, "R2 idle", {13'd0, busy, done, priv_err}, 16'h0);

    // table walk from the base user state
    for (int k = 0; k < 7; k++) begin
      logic [14:0] e;
      e = TBL[k];
      we0 = n_we;
      fire(e[14], e[13], e[12:10], e[9], e[8:1], lat);
      if (e[0]) begin
        chk(lat == 4, "R10 entry latency", 16'(lat), 16'd4);
        chk(last_pc == 16'h4000 + 16'(e[8:1]) * 16'd4, "R6 vector pc", last_pc, 16'h4000 + 16'(e[8:1]) * 16'd4);
        chk(last_r6 == 16'h2FFE, "R3 supervisor r6", last_r6, 16'h2FFE);
        chk(mem[12'hFFF] == 16'h8000, "R4 pushed psr", mem[12'hFFF], 16'h8000);
        chk(mem[12'hFFE] == 16'h0200, "R4 pushed pc", mem[12'hFFE], 16'h0200);
        chk(psr_out == {5'd0, e[12:10], 8'd0}, "R5 entry psr", psr_out, {5'd0, e[12:10], 8'd0});
        ret(lat);
        chk(lat == 3, "R10 return latency", 16'(lat), 16'd3);
        chk(last_pc == 16'h0200, "R7 restored pc", last_pc, 16'h0200);
        chk(last_r6 == 16'h0E00, "R7 restored user r6", last_r6, 16'h0E00);
        chk(psr_out == 16'h8000, "R7 restored psr", psr_out, 16'h8000);
      end else begin
        chk(lat == 0, "R1 no service", 16'(lat), 16'd0);
        chk(n_we == we0, "R1 no push", 16'(n_we - we0), 16'd0);
        chk(psr_out == 16'h8000, "R1 psr unchanged", psr_out, 16'h8000);
      end
    end

    // nested entry from privileged code
    fire(1, 1, 3'd3, 1, 8'h10, lat);
    chk(core_r6 == 16'h2FFE && core_pc == 16'h4040, "R3 outer entry", core_r6, 16'h2FFE);
    we0 = n_we;
    fire(1, 1, 3'd3, 1, 8'h11, lat);
    chk(lat == 0 && n_we == we0, "R1 equal level rejected", 16'(lat), 16'd0);
    fire(1, 1, 3'd6, 1, 8'h20, lat);
    chk(last_r6 == 16'h2FFC, "R3 no swap when privileged", last_r6, 16'h2FFC);
    chk(mem[12'hFFD] == 16'h0300, "R4 nested pushed psr", mem[12'hFFD], 16'h0300);
    chk(mem[12'hFFC] == 16'h4040, "R4 nested pushed pc", mem[12'hFFC], 16'h4040);
    chk(psr_out == 16'h0600, "R5 nested psr", psr_out, 16'h0600);
    ret(lat);
    chk(last_r6 == 16'h2FFE, "R8 nested return r6", last_r6, 16'h2FFE);
    chk(last_pc == 16'h4040, "R8 nested return pc", last_pc, 16'h4040);
    chk(psr_out == 16'h0300, "R8 nested return psr", psr_out, 16'h0300);
    ret(lat);
    chk(last_r6 == 16'h0E00 && psr_out == 16'h8000, "R7 outer return", last_r6, 16'h0E00);
    fire(1, 1, 3'd2, 1, 8'h01, lat);
    chk(last_r6 == 16'h2FFE, "R7 saved supervisor pointer", last_r6, 16'h2FFE);

    // R11 mask of restored word, condition codes cleared on next entry
    mem[12'hFFF] = 16'hF8F7;
    ret(lat);
    chk(psr_out == 16'h8007, "R11 masked psr", psr_out, 16'h8007);
    fire(1, 1, 3'd1, 1, 8'h02, lat);
    chk(mem[12'hFFF] == 16'h8007, "R4 pushes live codes", mem[12'hFFF], 16'h8007);
    chk(psr_out == 16'h0100, "R5 codes cleared", psr_out, 16'h0100);
    ret(lat);

    // R9 return from unprivileged code
    we0 = n_we; re0 = n_re;
    @(negedge clk); rti_req = 1;
    @(negedge clk); rti_req = 0;
    chk(priv_err == 1'b1, "R9 flag raised", {15'd0, priv_err}, 16'h1);
    @(negedge clk);
    chk(priv_err == 1'b0, "R9 flag single pulse", {15'd0, priv_err}, 16'h0);
    repeat (4) @(negedge clk);
    chk(n_re == re0 && n_we == we0, "R9 no memory access", 16'(n_re - re0), 16'd0);
    chk(core_pc == 16'h0200 && core_r6 == 16'h0E00, "R9 pc r6 kept", core_pc, 16'h0200);
    chk(psr_out == 16'h8007, "R9 psr kept", psr_out, 16'h8007);

    report();
  end
endmodule